// File: doc/BRIEF.md
# Input-Capture Timer with Selectable Count Source

This block is a 32-bit up-counter with a small register port. It holds a mode register, a reference register, a capture register and the counter itself. The counter advances once for every rising edge of one chosen source: every system clock, every sixteenth system clock, or the external timer pin. When the external pin shows the edge chosen in the mode register, the capture register records the counter value. Software uses the capture register to timestamp events on the pin and the counter to measure elapsed time.

The external pin is asynchronous. It passes through a two-flop synchronizer and an edge detector before it feeds either the counter or the capture logic. The pin cannot be the count source and the capture trigger at once. When the pin is the count source, pin edges never cause a capture, so that setting always behaves the same way. The register port is control traffic, not a data stream. It has no valid/ready handshake and no back-pressure. A write takes effect at the clock edge on which `bus_we` is sampled high. `bus_rdata` is a combinational function of `bus_addr`, and reading a register has no side effect.

Top module: `capture_timer`

## Requirements
- R1: After reset, the mode register reads 0 (count stopped, capture off), the reference register reads 0xFFFFFFFF, and the capture register and the counter both read 0.
- R2: The register map is: address 0 is mode, 1 is reference, 2 is capture, 3 is counter. Reading the counter at address 3 returns its current value and does not change the count.
- R3: A write to address 3 sets the counter to 0, whatever the write data. If a count step falls in the same cycle, the clear wins, so the counter reads 0 just after the write edge.
- R4: Mode bits [1:0] select the count source: 00 stopped, 01 system clock, 10 system clock divided by 16, 11 external pin. With 01 the counter rises by one on every clock edge. With 00 it holds its value.
- R5: With source 10, the counter rises by exactly one in every 16 consecutive system clocks, so it gains exactly 32 over any 512 clock edges.
- R6: With source 11, the counter rises by one for each rising edge of the pin, after a two-flop synchronizer. The pin must stay high for at least two clocks and low for at least two clocks.
- R7: Mode bits [3:2] select the capture edge: 00 off, 01 rising, 10 falling, 11 either. If the pin changes before clock edge E1, the capture register takes at edge E3 the value the counter held after edge E2.
- R8: While the count source is 11 (external pin), pin edges never change the capture register.
- R9: The reference register stores and returns all 32 bits written. The capture register is read-only, so writes to address 2 leave it unchanged. Mode bits above bit 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_pin | input | 1 | External timer pin, asynchronous |

## Verification
On every cycle, the assertions check that a counter write gives zero on the next cycle, that the system-clock source steps by exactly one, that a stopped counter and disabled or pin-clocked capture leave their registers unchanged, that prescaler ticks are isolated pulses, and that detected pin edges last one cycle. Only the bench scenarios can show the exact captured timestamp for each edge setting and pin polarity, the 32-in-512 count rate of the divided source, the pin-driven count, and the reset and readback values.

// File: rtl/captmr_pkg.sv
package captmr_pkg;
  typedef enum logic [1:0] {
    CLK_STOP  = 2'b00,
    CLK_SYS   = 2'b01,
    CLK_DIV16 = 2'b10,
    CLK_PIN   = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } cap_edge_e;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_REF  = 2'd1;
  localparam logic [1:0] A_CAP  = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;
endpackage

// File: rtl/captmr_sync.sv
module captmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

  // R6: a detected rising edge is a single-cycle pulse
  p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  // R7: a detected falling edge is a single-cycle pulse
  p_fall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/captmr_prescale.sv
module captmr_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R5: a prescaler tick never lasts two cycles
  p_tick_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import captmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cap_pin
);
  localparam int MODE_W = 4;

  clk_sel_e   sel_q;
  cap_edge_e  edge_q;
  logic [CNT_W-1:0] ref_q, cap_q, cnt_q;
  logic pin_rise, pin_fall, div_tick;
  logic cnt_en, cnt_clr, cap_ev;

  captmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin),
    .rise_o(pin_rise), .fall_o(pin_fall)
  );

  captmr_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(div_tick)
  );

  always_comb begin
    unique case (sel_q)
      CLK_SYS:   cnt_en = 1'b1;
      CLK_DIV16: cnt_en = div_tick;
      CLK_PIN:   cnt_en = pin_rise;
      default:   cnt_en = 1'b0;
    endcase
  end

  always_comb begin
    cap_ev = 1'b0;
    if (sel_q != CLK_PIN) begin
      unique case (edge_q)
        EDGE_RISE: cap_ev = pin_rise;
        EDGE_FALL: cap_ev = pin_fall;
        EDGE_BOTH: cap_ev = pin_rise | pin_fall;
        default:   cap_ev = 1'b0;
      endcase
    end
  end

  assign cnt_clr = bus_we && (bus_addr == A_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= CLK_STOP;
      edge_q <= EDGE_OFF;
      ref_q  <= '1;
    end else if (bus_we) begin
      if (bus_addr == A_MODE) begin
        sel_q  <= clk_sel_e'(bus_wdata[1:0]);
        edge_q <= cap_edge_e'(bus_wdata[3:2]);
      end
      if (bus_addr == A_REF) ref_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_ev) cap_q <= cnt_q;
  end

  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = {{(CNT_W-MODE_W){1'b0}}, edge_q, sel_q};
      A_REF:   bus_rdata = ref_q;
      A_CAP:   bus_rdata = cap_q;
      default: bus_rdata = cnt_q;
    endcase
  end

  // R3: a counter write leaves zero on the next cycle
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CNT) |=> (cnt_q == '0));
  // R4: system-clock source steps by one each cycle
  p_sys_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == CLK_SYS && !(bus_we && bus_addr == A_CNT))
      |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4: stopped counter holds
  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == CLK_STOP && !(bus_we && bus_addr == A_CNT)) |=> $stable(cnt_q));
  // R8: pin-clocked mode never captures
  p_pin_nocap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == CLK_PIN) |=> $stable(cap_q));
  // R7: capture off keeps the register
  p_edge_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q == EDGE_OFF) |=> $stable(cap_q));
endmodule

// File: tb/capture_timer_test.sv
module capture_timer_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       pin_from;
    logic       pin_to;
    logic [3:0] k;
    logic       hit;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd1, 1'b0, 1'b1, 4'd0, 1'b1},
    '{2'd1, 1'b1, 1'b0, 4'd3, 1'b0},
    '{2'd2, 1'b1, 1'b0, 4'd5, 1'b1},
    '{2'd2, 1'b0, 1'b1, 4'd1, 1'b0},
    '{2'd3, 1'b0, 1'b1, 4'd2, 1'b1},
    '{2'd3, 1'b1, 1'b0, 4'd7, 1'b1},
    '{2'd0, 1'b0, 1'b1, 4'd4, 1'b0},
    '{2'd0, 1'b1, 1'b0, 4'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_pin = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  capture_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic check(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    checks++;
    if (v !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d got 0x%08h expected 0x%08h", req, a, v, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    cycles(2);
    rst_n = 1'b1;
    cycles(1);

    // R1 reset values
    check("R1", 2'd0, 32'h0);
    check("R1", 2'd1, 32'hFFFF_FFFF);
    check("R1", 2'd2, 32'h0);
    check("R1", 2'd3, 32'h0);

    // capture vector table (R7), system-clock counting
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, {28'd0, VECS[i].edge_sel, 2'b01});
      cap_pin = VECS[i].pin_from;
      cycles(4);
      rd(2'd2, prev);
      wr(2'd3, 32'h0);
      cycles(int'(VECS[i].k));
      cap_pin = VECS[i].pin_to;
      cycles(4);
      check("R7", 2'd2, VECS[i].hit ? 32'(VECS[i].k) + 32'd2 : prev);
    end

    // R2 / R3 / R4: clear with non-zero data, reads do not disturb
    wr(2'd0, 32'h1);
    wr(2'd3, 32'hDEAD_BEEF);
    check("R3", 2'd3, 32'd0);
    cycles(3);
    check("R2", 2'd3, 32'd3);
    check("R2", 2'd3, 32'd3);
    cycles(5);
    check("R4", 2'd3, 32'd8);
    wr(2'd0, 32'h0);
    check("R4", 2'd3, 32'd9);
    cycles(10);
    check("R4", 2'd3, 32'd9);

    // R5 divided source
    wr(2'd0, 32'h2);
    wr(2'd3, 32'h0);
    cycles(512);
    check("R5", 2'd3, 32'd32);

    // R6 / R8 pin as count source with capture requested
    cap_pin = 1'b0;
    wr(2'd0, 32'h7);
    cycles(4);
    rd(2'd2, prev);
    wr(2'd3, 32'h0);
    for (int p = 0; p < 5; p++) begin
      cap_pin = 1'b1; cycles(3);
      cap_pin = 1'b0; cycles(3);
    end
    cycles(4);
    check("R6", 2'd3, 32'd5);
    check("R8", 2'd2, prev);

    // R9 reference, read-only capture, mode readback
    wr(2'd1, 32'hA5A5_0F0F);
    check("R9", 2'd1, 32'hA5A5_0F0F);
    rd(2'd2, prev);
    wr(2'd2, 32'h5555_5555);
    check("R9", 2'd2, prev);
    wr(2'd0, 32'hFFFF_FFF4);
    check("R9", 2'd0, 32'h4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule